// File: doc/BRIEF.md
# Instruction Decoder and Control-Word Generator

This block turns one 16-bit instruction of a small three-address, register-to-register machine into the control word that steers a datapath. The datapath has eight registers, an ALU, a data memory and two multiplexers. From the instruction the block produces the three register addresses, the register and memory write strobes, and the two multiplexer selects. It also produces the ALU function code, a sign-extended constant, jump and branch flags, and the branch condition.

The three most significant opcode bits pick the instruction category. Every instruction in a category gets the same strobes and selects. In the ALU and shift categories the four lower opcode bits go straight into the function code, so no lookup table is needed for those operations. The decode logic is combinational and ends in one output register with synchronous reset. A qualifier input, `in_valid`, marks each slot. An empty slot comes out as a bubble that writes nothing.

Top module: `idec_ctrl`

## Requirements
- R1: One cycle after a slot is presented, `wr_addr` equals instruction bits 8..6, `a_addr` equals bits 5..3 and `b_addr` equals bits 2..0, whatever the category.
- R2: Category 000 (bits 15..13, register ALU) gives `reg_we`=1, `b_sel_const`=0, `res_sel_mem`=0, `mem_we`=0, `alu_fn`={0, bits 12..9} and `const_val`=0.
- R3: Category 100 (immediate ALU) gives `reg_we`=1, `b_sel_const`=1, `res_sel_mem`=0, `mem_we`=0 and `alu_fn`={0, bits 12..9}. `const_val` is bits 2..0 read as a two's-complement value and sign-extended to DATA_W.
- R4: Category 101 (immediate shift) gives the same strobes, selects and constant as R3, with `alu_fn`={1, bits 12..9}. For example, bits 12..9 = 1000 gives `alu_fn`=11000.
- R5: Category 001 (load) gives `reg_we`=1, `res_sel_mem`=1, `b_sel_const`=0, `mem_we`=0, `alu_fn`=0 and `const_val`=0.
- R6: Category 010 (store) gives `mem_we`=1, `reg_we`=0, `b_sel_const`=0 and `res_sel_mem`=0. The register and memory strobes are never both high.
- R7: Category 110 (branch) gives `is_branch`=1, `cond_code`=bits 11..9 and no write strobe. Bit 12 has no effect on any output. `const_val` is the 6-bit offset {bits 8..6, bits 2..0} sign-extended, so it spans -32 to +31.
- R8: Category 111 (jump) gives `is_jump`=1, `is_branch`=0, no write strobe, and the same sign-extended 6-bit offset as R7.
- R9: Category 011 is unassigned. It raises no strobe and no flag, and `alu_fn`, `const_val` and `cond_code` are 0.
- R10: A slot with `in_valid`=0 gives `out_valid`=0, `reg_we`=0, `mem_we`=0, `is_jump`=0, `is_branch`=0 and `cond_code`=0 one cycle later. A slot with `in_valid`=1 gives `out_valid`=1.
- R11: While `rst` is high at a clock edge, every output is 0 after that edge.
- R12: `alu_fn` is 0 outside categories 000, 100 and 101. `const_val` is 0 in categories 000, 001, 010 and 011. `cond_code` is 0 outside category 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `instr` as a real instruction |
| instr | input | 16 | Instruction word |
| out_valid | output | 1 | Control word belongs to a real slot |
| wr_addr | output | 3 | Destination register address |
| a_addr | output | 3 | A-operand register address |
| b_addr | output | 3 | B-operand register address |
| reg_we | output | 1 | Register file write enable |
| b_sel_const | output | 1 | B operand taken from `const_val` instead of the register file |
| alu_fn | output | 5 | ALU function select |
| mem_we | output | 1 | Data memory write enable |
| res_sel_mem | output | 1 | Write-back value taken from memory instead of the ALU |
| const_val | output | DATA_W | Sign-extended immediate or jump/branch offset |
| is_jump | output | 1 | Jump instruction |
| is_branch | output | 1 | Branch instruction |
| cond_code | output | 3 | Branch condition select |

## Verification
The bench sends directed instructions from every category. These include immediates of 011 and 111 and offsets of 011111 and 100000, which separate sign extension from zero extension at both ends of each range. Two branches that differ only in bit 12 show that the unused bit is ignored. The bench also sends invalid slots that carry store and branch encodings, which show that a bubble raises no strobe. A long run of random words and random qualifiers then mixes all categories back to back. This exposes any state that leaks from one slot into the next.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int INSTR_W  = 16;
    localparam int RADDR_W  = 3;
    localparam int FNLOW_W  = 4;
    localparam int FN_W     = FNLOW_W + 1;
    localparam int COND_W   = 3;
    localparam int IMM_W    = 3;
    localparam int OFS_W    = 2 * RADDR_W;

    typedef enum logic [2:0] {
        CAT_ALU_REG   = 3'b000,
        CAT_LOAD      = 3'b001,
        CAT_STORE     = 3'b010,
        CAT_RSVD      = 3'b011,
        CAT_ALU_IMM   = 3'b100,
        CAT_SHIFT_IMM = 3'b101,
        CAT_BRANCH    = 3'b110,
        CAT_JUMP      = 3'b111
    } cat_e;

    typedef enum logic [1:0] {
        KSRC_NONE = 2'd0,
        KSRC_IMM  = 2'd1,
        KSRC_OFS  = 2'd2
    } ksrc_e;

    typedef struct packed {
        cat_e                 cat;
        logic [FNLOW_W-1:0]   fn_low;
        logic [RADDR_W-1:0]   dr;
        logic [RADDR_W-1:0]   sa;
        logic [RADDR_W-1:0]   sb;
    } fields_t;

    typedef struct packed {
        logic  reg_we;
        logic  mem_we;
        logic  b_sel_const;
        logic  res_sel_mem;
        logic  fn_pass;
        logic  fn_top;
        logic  is_jump;
        logic  is_branch;
        ksrc_e ksrc;
    } flags_t;

    function automatic fields_t split_word(input logic [INSTR_W-1:0] w);
        fields_t f;
        f.cat    = cat_e'(w[15:13]);
        f.fn_low = w[12:9];
        f.dr     = w[8:6];
        f.sa     = w[5:3];
        f.sb     = w[2:0];
        return f;
    endfunction

endpackage

// File: rtl/idec_split.sv
module idec_split
    import idec_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output fields_t            fields,
    output logic [IMM_W-1:0]   imm,
    output logic [OFS_W-1:0]   ofs
);
    always_comb begin
        fields = split_word(word);
        imm    = fields.sb;
        ofs    = {fields.dr, fields.sb};
    end
endmodule

// File: rtl/idec_category.sv
module idec_category
    import idec_pkg::*;
(
    input  cat_e   cat,
    output flags_t flags
);
    always_comb begin
        flags = '0;
        unique case (cat)
            CAT_ALU_REG: begin
                flags.reg_we  = 1'b1;
                flags.fn_pass = 1'b1;
            end
            CAT_LOAD: begin
                flags.reg_we      = 1'b1;
                flags.res_sel_mem = 1'b1;
            end
            CAT_STORE: begin
                flags.mem_we = 1'b1;
            end
            CAT_ALU_IMM: begin
                flags.reg_we      = 1'b1;
                flags.b_sel_const = 1'b1;
                flags.fn_pass     = 1'b1;
                flags.ksrc        = KSRC_IMM;
            end
            CAT_SHIFT_IMM: begin
                flags.reg_we      = 1'b1;
                flags.b_sel_const = 1'b1;
                flags.fn_pass     = 1'b1;
                flags.fn_top      = 1'b1;
                flags.ksrc        = KSRC_IMM;
            end
            CAT_BRANCH: begin
                flags.is_branch = 1'b1;
                flags.ksrc      = KSRC_OFS;
            end
            CAT_JUMP: begin
                flags.is_jump = 1'b1;
                flags.ksrc    = KSRC_OFS;
            end
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/idec_sext.sv
module idec_sext #(
    parameter int SRC_W = 3,
    parameter int DST_W = 16
) (
    input  logic [SRC_W-1:0] src,
    output logic [DST_W-1:0] dst
);
    assign dst[SRC_W-1:0] = src;
    generate
        for (genvar g = SRC_W; g < DST_W; g++) begin : g_ext
            assign dst[g] = src[SRC_W-1];
        end
    endgenerate
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    output logic                out_valid,
    output logic [RADDR_W-1:0]  wr_addr,
    output logic [RADDR_W-1:0]  a_addr,
    output logic [RADDR_W-1:0]  b_addr,
    output logic                reg_we,
    output logic                b_sel_const,
    output logic [FN_W-1:0]     alu_fn,
    output logic                mem_we,
    output logic                res_sel_mem,
    output logic [DATA_W-1:0]   const_val,
    output logic                is_jump,
    output logic                is_branch,
    output logic [COND_W-1:0]   cond_code
);
    fields_t              fld;
    flags_t               flg;
    logic [IMM_W-1:0]     imm_raw;
    logic [OFS_W-1:0]     ofs_raw;
    logic [DATA_W-1:0]    imm_ext;
    logic [DATA_W-1:0]    ofs_ext;
    logic [DATA_W-1:0]    const_n;
    logic [FN_W-1:0]      fn_n;
    logic [COND_W-1:0]    cond_n;

    idec_split u_split (
        .word   (instr),
        .fields (fld),
        .imm    (imm_raw),
        .ofs    (ofs_raw)
    );

    idec_category u_cat (
        .cat   (fld.cat),
        .flags (flg)
    );

    idec_sext #(.SRC_W(IMM_W), .DST_W(DATA_W)) u_sext_imm (
        .src (imm_raw),
        .dst (imm_ext)
    );

    idec_sext #(.SRC_W(OFS_W), .DST_W(DATA_W)) u_sext_ofs (
        .src (ofs_raw),
        .dst (ofs_ext)
    );

    always_comb begin
        unique case (flg.ksrc)
            KSRC_IMM: const_n = imm_ext;
            KSRC_OFS: const_n = ofs_ext;
            default:  const_n = '0;
        endcase
        fn_n   = flg.fn_pass ? {flg.fn_top, fld.fn_low} : '0;
        cond_n = (flg.is_branch && in_valid) ? fld.fn_low[COND_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            wr_addr     <= '0;
            a_addr      <= '0;
            b_addr      <= '0;
            reg_we      <= 1'b0;
            b_sel_const <= 1'b0;
            alu_fn      <= '0;
            mem_we      <= 1'b0;
            res_sel_mem <= 1'b0;
            const_val   <= '0;
            is_jump     <= 1'b0;
            is_branch   <= 1'b0;
            cond_code   <= '0;
        end else begin
            out_valid   <= in_valid;
            wr_addr     <= fld.dr;
            a_addr      <= fld.sa;
            b_addr      <= fld.sb;
            reg_we      <= in_valid & flg.reg_we;
            b_sel_const <= flg.b_sel_const;
            alu_fn      <= fn_n;
            mem_we      <= in_valid & flg.mem_we;
            res_sel_mem <= flg.res_sel_mem;
            const_val   <= const_n;
            is_jump     <= in_valid & flg.is_jump;
            is_branch   <= in_valid & flg.is_branch;
            cond_code   <= cond_n;
        end
    end
endmodule

// File: rtl/idec_ctrl_chk.sv
module idec_ctrl_chk
    import idec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [INSTR_W-1:0]  instr,
    input logic                out_valid,
    input logic [RADDR_W-1:0]  wr_addr,
    input logic [RADDR_W-1:0]  a_addr,
    input logic [RADDR_W-1:0]  b_addr,
    input logic                reg_we,
    input logic                b_sel_const,
    input logic [FN_W-1:0]     alu_fn,
    input logic                mem_we,
    input logic                res_sel_mem,
    input logic [DATA_W-1:0]   const_val,
    input logic                is_jump,
    input logic                is_branch,
    input logic [COND_W-1:0]   cond_code
);
    AST_FIELD_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (wr_addr == $past(instr[8:6]) && a_addr == $past(instr[5:3])
                      && b_addr == $past(instr[2:0]))); // R1

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10

    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !reg_we && !mem_we && !is_jump && !is_branch
                       && cond_code == '0)); // R10

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && mem_we)); // R6

    AST_STORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:13] == 3'b010) |=> (mem_we && !reg_we)); // R6

    AST_FLOW_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (is_jump || is_branch) |-> (!reg_we && !mem_we && $onehot0({is_jump, is_branch}))); // R7

    AST_IMM_PATH: assert property (@(posedge clk) disable iff (rst)
        b_sel_const |-> (reg_we || !out_valid) && !res_sel_mem); // R3

    AST_LOAD_PATH: assert property (@(posedge clk) disable iff (rst)
        res_sel_mem |-> !b_sel_const && !mem_we); // R5

    AST_SHIFT_FN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:13] == 3'b101) |=> (alu_fn[FN_W-1] && b_sel_const)); // R4

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:13] == 3'b011) |=> (!reg_we && !mem_we && !is_jump
                                                  && !is_branch && alu_fn == '0
                                                  && const_val == '0)); // R9

    AST_COND_ONLY_BRANCH: assert property (@(posedge clk) disable iff (rst)
        !is_branch |-> cond_code == '0); // R12

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !reg_we && !mem_we && !is_jump && !is_branch
                 && const_val == '0)); // R11
endmodule

bind idec_ctrl idec_ctrl_chk #(.DATA_W(DATA_W)) u_idec_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .instr       (instr),
    .out_valid   (out_valid),
    .wr_addr     (wr_addr),
    .a_addr      (a_addr),
    .b_addr      (b_addr),
    .reg_we      (reg_we),
    .b_sel_const (b_sel_const),
    .alu_fn      (alu_fn),
    .mem_we      (mem_we),
    .res_sel_mem (res_sel_mem),
    .const_val   (const_val),
    .is_jump     (is_jump),
    .is_branch   (is_branch),
    .cond_code   (cond_code)
);

// File: tb/idec_ctrl_bench.sv
module idec_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [15:0]       instr = 16'h0000;
    logic              out_valid;
    logic [2:0]        wr_addr, a_addr, b_addr;
    logic              reg_we, b_sel_const, mem_we, res_sel_mem;
    logic [4:0]        alu_fn;
    logic [DATA_W-1:0] const_val;
    logic              is_jump, is_branch;
    logic [2:0]        cond_code;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic              v;
        logic [2:0]        da, aa, ba;
        logic              we, mb, mw, md, jmp, br;
        logic [4:0]        fn;
        logic [DATA_W-1:0] k;
        logic [2:0]        cond;
        logic [2:0]        cls;
    } exp_t;

    exp_t pending[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    idec_ctrl #(.DATA_W(DATA_W)) u_idec_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .out_valid(out_valid), .wr_addr(wr_addr), .a_addr(a_addr), .b_addr(b_addr),
        .reg_we(reg_we), .b_sel_const(b_sel_const), .alu_fn(alu_fn), .mem_we(mem_we),
        .res_sel_mem(res_sel_mem), .const_val(const_val), .is_jump(is_jump),
        .is_branch(is_branch), .cond_code(cond_code)
    );

    function automatic exp_t model(input logic v, input logic [15:0] w);
        exp_t e;
        int   k;
        e     = '0;
        e.v   = v;
        e.cls = w[15:13];
        e.da  = w[8:6];
        e.aa  = w[5:3];
        e.ba  = w[2:0];
        k     = 0;
        case (int'(w[15:13]))
            0: begin e.we = 1; e.fn = {1'b0, w[12:9]}; end
            1: begin e.we = 1; e.md = 1; end
            2: begin e.mw = 1; end
            4, 5: begin
                e.we = 1; e.mb = 1;
                e.fn = {(w[15:13] == 3'b101), w[12:9]};
                k = int'(w[2:0]);
                if (k > 3) k = k - 8;
                e.k = k[DATA_W-1:0];
            end
            6, 7: begin
                if (w[13]) e.jmp = 1;
                else begin e.br = 1; e.cond = w[11:9]; end
                k = int'(w[8:6]) * 8 + int'(w[2:0]);
                if (k > 31) k = k - 64;
                e.k = k[DATA_W-1:0];
            end
            default: ;
        endcase
        if (!v) begin
            e.we = 0; e.mw = 0; e.jmp = 0; e.br = 0; e.cond = '0;
        end
        return e;
    endfunction

    function automatic string cls_tag(input exp_t e);
        if (!e.v) return "R10";
        case (e.cls)
            3'd0: return "R2";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R9";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        string t;
        string ot;
        t = cls_tag(e);
        // operand fields: zero expectations in non-ALU/non-flow classes belong to R12
        ot = (e.cls == 3'd1 || e.cls == 3'd2 || e.cls == 3'd3) ? "R12" : t;
        check("R1", 64'({e.da, e.aa, e.ba}), 64'({wr_addr, a_addr, b_addr}) , "addr");
        check(t, 64'({out_valid, reg_we, b_sel_const, mem_we, res_sel_mem, is_jump, is_branch}),
                 64'({e.v, e.we, e.mb, e.mw, e.md, e.jmp, e.br}), "strobes");
        check(ot, 64'({alu_fn, const_val, cond_code}), 64'({e.fn, e.k, e.cond}), "operands");
    endtask

    task automatic step(input logic v, input logic [15:0] w);
        @(negedge clk);
        if (pending.size() > 0) compare(pending.pop_front());
        in_valid = v;
        instr    = w;
        pending.push_back(model(v, w));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        in_valid = 1'b1;
        instr    = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R11: reset clears every output despite a valid jump at the input
        check("R11", 64'({out_valid, reg_we, mem_we, is_jump, is_branch, b_sel_const, res_sel_mem}), 64'(0), "ctrl");
        check("R11", 64'({wr_addr, a_addr, b_addr, alu_fn, cond_code}), 64'(0), "fields");
        check("R11", 64'(const_val), 64'(0), "const");
        rst = 1'b0;
        in_valid = 1'b0;

        step(1, {3'b000, 4'b1100, 3'd1, 3'd2, 3'd3});   // R2 register XOR
        step(1, {3'b100, 4'b0010, 3'd4, 3'd5, 3'b111}); // R3 imm -1
        step(1, {3'b100, 4'b0010, 3'd4, 3'd5, 3'b011}); // R3 imm +3
        step(1, {3'b101, 4'b1000, 3'd6, 3'd7, 3'b100}); // R4 shift left imm -4
        step(1, {3'b001, 4'b0000, 3'd2, 3'd3, 3'd0});   // R5 load
        step(1, {3'b010, 4'b0000, 3'd0, 3'd1, 3'd5});   // R6 store
        step(1, {3'b110, 4'b0011, 3'b100, 3'd3, 3'b000}); // R7 BZ offset -32
        step(1, {3'b110, 4'b1011, 3'b100, 3'd3, 3'b000}); // R7 bit12 set: same result
        step(1, {3'b110, 4'b0101, 3'b011, 3'd1, 3'b111}); // R7 offset +31
        step(1, {3'b111, 4'b0000, 3'b000, 3'd0, 3'b010}); // R8 jump +2
        step(1, {3'b111, 4'b1111, 3'b111, 3'd0, 3'b000}); // R8 jump -8
        step(1, {3'b011, 4'b1111, 3'd7, 3'd7, 3'd7});   // R9 unassigned
        step(0, {3'b010, 4'b0000, 3'd1, 3'd2, 3'd3});   // R10 bubble store
        step(0, {3'b110, 4'b0011, 3'd1, 3'd2, 3'd3});   // R10 bubble branch
        step(1, {3'b000, 4'b0101, 3'd7, 3'd0, 3'd6});   // R2 back to back

        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, 16'($urandom));
        end
        @(negedge clk);
        if (pending.size() > 0) compare(pending.pop_front());

        done = 1'b1;
        finish_run();
    end
endmodule